// File: doc/BRIEF.md
# Ethernet Port Status LED Controller

This block turns the status of a 10/100 Ethernet port into indicator lamps. The MAC and PHY supply a link-up level, a speed level (100 or 10 Mbps), a full-duplex level, and single-cycle pulses for receive activity, transmit activity and collisions. The block drives four active-high LED lines. A mode input picks between two layouts. The compact layout uses three lamps and merges link with activity, and duplex with collision. The wide layout uses four lamps and gives each link speed its own lamp plus a separate activity lamp.

The block makes its own 10 Hz and 20 Hz square waves from a system clock whose frequency is a parameter. Every activity or collision pulse is stretched by a retriggerable hold timer, so a single short frame still gives a visible blink.

Two small state machines do the work. The link tracker has three states: `LS_DOWN`, `LS_UP10` and `LS_UP100`. It takes the transition to `LS_DOWN` from any state when link-up falls. It goes from `LS_DOWN` to `LS_UP10` or `LS_UP100` when the link comes up, choosing by the speed level. It moves between `LS_UP10` and `LS_UP100` when the speed changes while the link stays up. Each of the two hold timers has two states: `SX_IDLE` and `SX_HOLD`. A timer goes from `SX_IDLE` to `SX_HOLD` on a pulse while the link is up. In `SX_HOLD`, a new pulse reloads the timer. A timer returns from `SX_HOLD` to `SX_IDLE` when its count runs out or when the link drops.

Top module: `eth_led_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all four LEDs are 0 after that edge, and all blink counters and hold timers restart from zero.
- R2: `mode_four`=0 selects the three-lamp layout: led[0] is speed, led[1] is link/activity, led[2] is duplex/collision, and led[3] is held at 0. `mode_four`=1 selects the four-lamp layout: led[0] is the 100 Mbps link, led[1] is the 10 Mbps link, led[2] is activity, and led[3] is duplex/collision.
- R3: In the three-lamp layout with the link up, led[0] is 1 when `speed_100`=1 and 0 when `speed_100`=0.
- R4: In the three-lamp layout with the link up, led[1] is steadily 1 when no activity is being held. While activity is held, led[1] follows the 10 Hz square wave.
- R5: In the four-lamp layout, led[0] is 1 only for an up 100 Mbps link, and led[1] is 1 only for an up 10 Mbps link.
- R6: In the four-lamp layout, led[2] is 0 when no activity is being held, and follows the 10 Hz square wave while activity is held.
- R7: The duplex lamp (led[2] in the three-lamp layout, led[3] in the four-lamp layout) equals `full_duplex` while the link is up and no collision is held. While a collision is held, the duplex lamp follows the 20 Hz square wave, even when `full_duplex` is 1.
- R8: A pulse on `rx_act` or `tx_act` holds activity for HOLD_MS·(CLK_HZ/1000) cycles, and a pulse on `col_det` holds collision for the same time. A new pulse restarts the hold. When the hold runs out, the lamp returns to its steady value.
- R9: While `link_up`=0, all four LEDs are 0. Activity and collision pulses that arrive while the link is down have no effect after the link comes back up.
- R10: The 10 Hz wave has a half period of CLK_HZ/20 cycles and the 20 Hz wave has a half period of CLK_HZ/40 cycles. Both waves have a 50% duty cycle, so over any full period a blinking lamp is lit for exactly half the cycles.
- R11: A change on `link_up`, `speed_100`, `full_duplex` or `mode_four` shows up on `led` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| mode_four | input | 1 | 0 = three-lamp layout, 1 = four-lamp layout |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | 1 = 100 Mbps link, 0 = 10 Mbps link |
| full_duplex | input | 1 | Full-duplex operation |
| rx_act | input | 1 | Single-cycle receive activity pulse |
| tx_act | input | 1 | Single-cycle transmit activity pulse |
| col_det | input | 1 | Single-cycle collision pulse |
| led | output | 4 | Active-high LED lines, mapped as in R2 |

## Verification
The bench measures each blinking lamp over exactly one full wave period and counts how many cycles it is lit. A wrong divider or a wrong duty cycle changes that count, and a collision blink that fails to override full duplex shows up as a lamp lit for the whole window. Pulses are repeated faster than the hold time over several periods, so a hold timer that is not reloaded would let the lamp go steady partway through the window. Pulses given while the link is down, followed by link-up, catch a timer that was armed anyway: the lamp would blink instead of staying steady. A cycle-exact check after a speed change catches a missing or extra register stage.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

    typedef enum logic [1:0] {
        LS_DOWN  = 2'd0,
        LS_UP10  = 2'd1,
        LS_UP100 = 2'd2
    } link_state_e;

    typedef enum logic {
        SX_IDLE = 1'b0,
        SX_HOLD = 1'b1
    } stretch_state_e;

endpackage

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int HALF = 200
) (
    input  logic clk,
    input  logic rst,
    output logic wave
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wave_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            wave_q <= ~wave_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wave = wave_q;

    // R10: the wave may only change state when a half period has elapsed
    assert_toggle_at_half_R10: assert property (@(posedge clk) disable iff (rst)
        (wave_q != $past(wave_q)) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch
    import eth_led_pkg::*;
#(
    parameter int HOLD = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic trig,
    output logic active
);
    localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [HW-1:0] LOAD = HW'(HOLD - 1);

    stretch_state_e state_q, state_d;
    logic [HW-1:0]  cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SX_IDLE: begin
                if (en && trig) begin
                    state_d = SX_HOLD;
                    cnt_d   = LOAD;
                end
            end
            SX_HOLD: begin
                if (!en) begin
                    state_d = SX_IDLE;
                    cnt_d   = '0;
                end else if (trig) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = SX_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = SX_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign active = (state_q == SX_HOLD);

    // R8: a pulse with the link up (re)starts a full hold
    assert_retrigger_R8: assert property (@(posedge clk) disable iff (rst)
        (en && trig) |=> (state_q == SX_HOLD && cnt_q == LOAD));

    // R8: an exhausted hold with no new pulse ends
    assert_expire_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == SX_HOLD && cnt_q == '0 && !trig) |=> (state_q == SX_IDLE));

    // R9: no hold survives a link drop
    assert_drop_on_down_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_q == SX_IDLE));

endmodule

// File: rtl/eth_led_ctrl.sv
module eth_led_ctrl
    import eth_led_pkg::*;
#(
    parameter int CLK_HZ  = 25_000_000,
    parameter int HOLD_MS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_four,
    input  logic       link_up,
    input  logic       speed_100,
    input  logic       full_duplex,
    input  logic       rx_act,
    input  logic       tx_act,
    input  logic       col_det,
    output logic [3:0] led
);
    localparam int HALF_SLOW = CLK_HZ / 20;
    localparam int HALF_FAST = CLK_HZ / 40;
    localparam int HOLD_CYC  = (CLK_HZ / 1000) * HOLD_MS;
    localparam int NCH       = 2;   // channel 0 = activity, 1 = collision

    link_state_e ls_q, ls_d;
    logic        fdx_q, four_q;
    logic        blink_slow, blink_fast;
    logic [NCH-1:0] trig_vec, held_vec;
    logic [3:0]  led_d, led_q;

    led_blink_gen #(.HALF(HALF_SLOW)) u_blink_slow (
        .clk (clk), .rst (rst), .wave (blink_slow)
    );
    led_blink_gen #(.HALF(HALF_FAST)) u_blink_fast (
        .clk (clk), .rst (rst), .wave (blink_fast)
    );

    assign trig_vec = {col_det, rx_act | tx_act};

    for (genvar g = 0; g < NCH; g++) begin : g_hold
        led_pulse_stretch #(.HOLD(HOLD_CYC)) u_hold (
            .clk    (clk),
            .rst    (rst),
            .en     (link_up),
            .trig   (trig_vec[g]),
            .active (held_vec[g])
        );
    end

    // link tracker transitions
    always_comb begin
        if (!link_up)       ls_d = LS_DOWN;
        else if (speed_100) ls_d = LS_UP100;
        else                ls_d = LS_UP10;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            ls_q   <= LS_DOWN;
            fdx_q  <= 1'b0;
            four_q <= 1'b0;
        end else begin
            ls_q   <= ls_d;
            fdx_q  <= full_duplex;
            four_q <= mode_four;
        end
    end

    // output decode
    always_comb begin
        logic fast_lane;
        logic dpx;
        fast_lane = (ls_q == LS_UP100);
        dpx       = held_vec[1] ? blink_fast : fdx_q;
        led_d     = 4'b0000;
        unique case (ls_q)
            LS_DOWN: led_d = 4'b0000;
            LS_UP10, LS_UP100: begin
                if (four_q)
                    led_d = {dpx, held_vec[0] & blink_slow, ~fast_lane, fast_lane};
                else
                    led_d = {1'b0, dpx, held_vec[0] ? blink_slow : 1'b1, fast_lane};
            end
            default: led_d = 4'b0000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) led_q <= 4'b0000;
        else     led_q <= led_d;
    end

    assign led = led_q;

    // R1: reset darkens every lamp on the following edge
    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (led_q == 4'b0000));

    // R2: three-lamp layout keeps the spare lamp off
    assert_spare_low_R2: assert property (@(posedge clk) disable iff (rst)
        !four_q |=> !led_q[3]);

    // R3: speed lamp in three-lamp layout
    assert_speed_lamp_R3: assert property (@(posedge clk) disable iff (rst)
        (!four_q && ls_q == LS_UP100) |=> led_q[0]);

    // R5: four-lamp layout never shows both link speeds
    assert_speed_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        four_q |=> $onehot0(led_q[1:0]));

    // R9: link down means all dark
    assert_dark_when_down_R9: assert property (@(posedge clk) disable iff (rst)
        (ls_q == LS_DOWN) |=> (led_q == 4'b0000));

endmodule

// File: tb/sim_eth_led_ctrl.sv
module sim_eth_led_ctrl;
    localparam int CLK_HZ  = 4000;   // half periods: 200 (10 Hz), 100 (20 Hz)
    localparam int HOLD_MS = 100;    // hold = 400 cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_four = 1'b1, link_up = 1'b1, speed_100 = 1'b1, full_duplex = 1'b1;
    logic rx_act = 1'b0, tx_act = 1'b0, col_det = 1'b0;
    logic [3:0] led;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    string      q_req[$];
    logic [3:0] q_exp[$];

    always #2 clk = ~clk;   // 250 MHz

    eth_led_ctrl #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) u0 (
        .clk(clk), .rst(rst), .mode_four(mode_four), .link_up(link_up),
        .speed_100(speed_100), .full_duplex(full_duplex), .rx_act(rx_act),
        .tx_act(tx_act), .col_det(col_det), .led(led)
    );

    // monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            string      r;
            logic [3:0] e;
            r = q_req.pop_front();
            e = q_exp.pop_front();
            tests_run++;
            if (led !== e) begin
                tests_failed++;
                $display("FAIL %s led actual=%b expected=%b", r, led, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle(int n);
        repeat (n) tick();
    endtask

    // driver: queue an expectation for the coming falling edge
    task automatic expect_led(string r, logic [3:0] e);
        q_req.push_back(r);
        q_exp.push_back(e);
        tick();
    endtask

    task automatic check(string r, int act, int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic measure(int idx, int n, bit p_act, bit p_col, output int ones);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            rx_act  = p_act && (i % 100 == 0);
            col_det = p_col && (i % 100 == 0);
            @(negedge clk);
            ones += int'(led[idx]);
            @(posedge clk); #1;
        end
        rx_act  = 1'b0;
        col_det = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_act = 1'b1; tick(); rx_act = 1'b0; settle(4);
    endtask

    task automatic pulse_col();
        col_det = 1'b1; tick(); col_det = 1'b0; settle(4);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int ones;
        #1;
        // R1: reset holds everything dark
        settle(3);
        expect_led("R1 reset", 4'b0000);
        rst = 1'b0;

        // three-lamp layout, 100 Mbps full duplex idle: R2 R3 R4 R7
        mode_four = 1'b0;
        settle(4);
        expect_led("R3/R4/R7 3-lamp 100 fdx", 4'b0111);
        speed_100 = 1'b0; full_duplex = 1'b0;
        settle(4);
        expect_led("R3 3-lamp 10 half", 4'b0010);

        // four-lamp layout: R2 R5 R7
        mode_four = 1'b1; speed_100 = 1'b1; full_duplex = 1'b1;
        settle(4);
        expect_led("R5/R7 4-lamp 100 fdx", 4'b1001);
        full_duplex = 1'b0;
        settle(4);
        expect_led("R7 4-lamp half duplex", 4'b0001);

        // R11: speed change seen exactly two edges later
        speed_100 = 1'b0;
        q_req.push_back("R11 before edge"); q_exp.push_back(4'b0001); tick();
        expect_led("R11 after one edge", 4'b0001);
        expect_led("R11 after two edges R5 10M", 4'b0010);

        // R9: link down darkens all in both layouts
        link_up = 1'b0;
        settle(4);
        expect_led("R9 down 4-lamp", 4'b0000);
        mode_four = 1'b0;
        settle(4);
        expect_led("R9 down 3-lamp", 4'b0000);

        // R4 R10: activity blink in three-lamp layout
        link_up = 1'b1; speed_100 = 1'b1; full_duplex = 1'b1;
        settle(4);
        pulse_rx();
        measure(1, 400, 1'b1, 1'b0, ones);
        check("R4/R10 3-lamp activity duty", ones, 200);
        // R8: retrigger keeps the blink across three periods
        measure(1, 1200, 1'b1, 1'b0, ones);
        check("R8 retrigger held", ones, 600);
        // R8: expiry returns to steady
        settle(420);
        expect_led("R8 expired steady", 4'b0111);

        // R8: a single transmit pulse still blinks
        tx_act = 1'b1; tick(); tx_act = 1'b0; settle(3);
        measure(1, 300, 1'b0, 1'b0, ones);
        check("R8 single pulse visible", int'(ones < 300), 1);
        settle(450);
        measure(1, 100, 1'b0, 1'b0, ones);
        check("R8 single pulse expiry", ones, 100);

        // R7 R10 R2: collision overrides fdx in three-lamp layout, spare stays low
        pulse_col();
        measure(2, 200, 1'b0, 1'b1, ones);
        check("R7/R10 3-lamp collision duty", ones, 100);
        measure(3, 200, 1'b0, 1'b1, ones);
        check("R2 spare lamp low", ones, 0);
        settle(420);

        // R6 R10: activity lamp in four-lamp layout
        mode_four = 1'b1;
        settle(4);
        expect_led("R6 idle activity dark", 4'b1001);
        pulse_rx();
        measure(2, 400, 1'b1, 1'b0, ones);
        check("R6/R10 4-lamp activity duty", ones, 200);
        settle(420);
        expect_led("R6 activity expired", 4'b1001);

        // R7: collision on the fourth lamp
        pulse_col();
        measure(3, 200, 1'b0, 1'b1, ones);
        check("R7 4-lamp collision duty", ones, 100);
        settle(420);

        // R9: pulses while down are ignored after link returns
        mode_four = 1'b0;
        link_up = 1'b0;
        settle(3);
        rx_act = 1'b1; col_det = 1'b1; tick();
        rx_act = 1'b0; col_det = 1'b0; settle(2);
        link_up = 1'b1;
        settle(4);
        measure(1, 300, 1'b0, 1'b0, ones);
        check("R9 no stale activity", ones, 300);
        measure(2, 80, 1'b0, 1'b0, ones);
        check("R9 no stale collision", ones, 80);

        // R1: reset in the middle of traffic
        pulse_rx();
        rst = 1'b1;
        settle(2);
        expect_led("R1 mid-run reset", 4'b0000);
        rst = 1'b0;
        settle(4);
        expect_led("R1 recovers steady", 4'b0111);

        settle(2);
        finish_up();
    end
endmodule